// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. A 16-bit down-counter is configured through an 8-bit control word and loaded or read one byte at a time over a simple byte port. Three output behaviours are offered. The first raises OUT once after a programmed delay. The second drops OUT for one count every N counts. The third is a square wave at 1/N of the count rate. Only binary counting is supported. A count pulse input (`cnt_tick`) marks each counting edge, and a `gate` input pauses or restarts counting, with an effect that depends on the mode.

Software first writes a control word that picks the mode and the byte order for count transfers. It then writes the initial count. The first count pulse after the final byte loads the counter, and counting starts on the pulses after that. To read a running counter without tearing the value, software issues a latch command that freezes a snapshot. It then reads the snapshot back while the counter keeps running.

Top module: `interval_counter_channel`

## Requirements
- R1: A control write has `sel_ctrl`=1, and its fields are decoded from `wr_data` as follows. Bits 7:6 must equal `CHANNEL_ID` (default 0). Bits 5:4 give the access: 00 latch command, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 3:1 give the mode: 000 terminal count, 010 or 110 rate generator, 011 or 111 square wave. Bit 0 must be 0. Any non-latch control word clears the byte sequencing and releases any snapshot.
- R2: A control word is ignored completely, leaving mode, access and OUT unchanged, if bits 7:6 name another channel, if bit 0 is 1, or if bits 3:1 are 001, 100 or 101.
- R3: After reset the mode is terminal count, the access is low then high, OUT is high, the count is 0 and `rd_data` reads 0x00.
- R4: With low-then-high access, writing only the low byte starts nothing. The new count takes effect only once the high byte follows. Low-only access loads {0x00, byte}, and high-only access loads {byte, 0x00}.
- R5: The count is loaded on the first `cnt_tick` after the final count byte. It is decremented only on later ticks, so a read right after the load tick returns N.
- R6: In terminal-count mode, OUT goes low on the clock after a control word or a completed count write. It goes high on the (N+1)th tick after the count write and stays high until the next count write.
- R7: In terminal-count mode, ticks that arrive while `gate` is low neither decrement the count nor change OUT.
- R8: In rate mode, OUT is low for exactly one tick per period of N ticks, while the count is 1, and the count then reloads. A loaded value of 1 acts as 2 in both periodic modes.
- R9: In square-wave mode, OUT is high for ceil(N/2) ticks and low for floor(N/2) ticks of every N-tick period, starting high.
- R10: In rate and square-wave modes, `gate` low forces OUT high on the next clock and holds the count. A rising edge of `gate` makes the next tick reload N and restart the period.
- R11: An initial count of 0 stands for 65536. In terminal-count mode, OUT rises on the 65537th tick.
- R12: A latch command stores the current count. Reads return that snapshot until it has been fully read in the current access order (both bytes for low-then-high). A second latch command before then is ignored.
- R13: With no snapshot held, a data read (`sel_ctrl`=0) returns the live count. The byte is low for low-only access, high for high-only access, and low then high, alternating, for low-then-high access. `rd_data` shows the byte the next read consumes, and `rd_en` advances the order.
- R14: In rate and square-wave modes, a count written while the counter runs takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, one clock |
| rd_en | input | 1 | Byte read strobe, one clock; advances the read order |
| sel_ctrl | input | 1 | 1 selects the control word, 0 selects count data |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Byte presented for the next count read |
| cnt_tick | input | 1 | Counting pulse, one clock wide |
| gate | input | 1 | Gate input (pause, force, restart) |
| out | output | 1 | Counter output |

## Verification
The hardest state to reach from the ports is a snapshot that survives while the counter keeps moving. Reaching it needs a latch command and a second, ignored latch command separated by count pulses, followed by a split two-byte read. The stimulus then reads the live count straight away to show that the snapshot was released. Another hard state is a gate rising edge in square-wave mode while OUT is in its low half. The bench drops `gate`, sends ticks that must not move the count, raises `gate` on a clock with no tick, and then compares the reloaded count and the restarted duty pattern against values computed arithmetically from N.

// File: rtl/icc_pkg.sv
package icc_pkg;

    typedef enum logic [1:0] {
        MODE_TC     = 2'd0,
        MODE_RATE   = 2'd1,
        MODE_SQUARE = 2'd2
    } icc_mode_e;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } icc_access_e;

    // Mode field supported: 000, x10, x11
    function automatic logic mode_supported(input logic [2:0] m);
        return (m == 3'b000) || m[1];
    endfunction

    function automatic icc_mode_e mode_decode(input logic [2:0] m);
        if (!m[1])     return MODE_TC;
        else if (m[0]) return MODE_SQUARE;
        else           return MODE_RATE;
    endfunction

endpackage

// File: rtl/icc_host_port.sv
module icc_host_port
    import icc_pkg::*;
#(
    parameter int         DATA_W  = 8,
    parameter logic [1:0] CHAN_ID = 2'd0
)
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  sel_ctrl,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [2*DATA_W-1:0]   count_live,
    output icc_mode_e             mode_q,
    output logic                  cfg_load,
    output icc_mode_e             cfg_mode,
    output logic                  commit,
    output logic [2*DATA_W-1:0]   init_q,
    output logic                  snap_held,
    output logic [2*DATA_W-1:0]   snap_val,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        icc_mode_e          mode;
        icc_access_e        acc;
        logic               wr_hi;
        logic [DATA_W-1:0]  lo_stage;
        logic [CNT_W-1:0]   init;
        logic               rd_hi;
        logic               latched;
        logic [CNT_W-1:0]   snap;
    } host_st_t;

    host_st_t q, d;
    logic ctrl_hit;
    logic hi_sel;
    logic [CNT_W-1:0] rd_src;

    always_comb begin
        d        = q;
        commit   = 1'b0;
        cfg_load = 1'b0;
        cfg_mode = mode_decode(wr_data[3:1]);
        ctrl_hit = wr_en && sel_ctrl && (wr_data[7:6] == CHAN_ID);

        if (ctrl_hit) begin
            if (icc_access_e'(wr_data[5:4]) == ACC_LATCH) begin
                if (!q.latched) begin
                    d.latched = 1'b1;
                    d.snap    = count_live;
                    d.rd_hi   = 1'b0;
                end
            end else if (mode_supported(wr_data[3:1]) && !wr_data[0]) begin
                cfg_load  = 1'b1;
                d.mode    = cfg_mode;
                d.acc     = icc_access_e'(wr_data[5:4]);
                d.wr_hi   = 1'b0;
                d.rd_hi   = 1'b0;
                d.latched = 1'b0;
            end
        end else if (wr_en && !sel_ctrl) begin
            case (q.acc)
                ACC_LO: begin
                    d.init = {{DATA_W{1'b0}}, wr_data};
                    commit = 1'b1;
                end
                ACC_HI: begin
                    d.init = {wr_data, {DATA_W{1'b0}}};
                    commit = 1'b1;
                end
                default: begin
                    if (!q.wr_hi) begin
                        d.lo_stage = wr_data;
                        d.wr_hi    = 1'b1;
                    end else begin
                        d.init  = {wr_data, q.lo_stage};
                        d.wr_hi = 1'b0;
                        commit  = 1'b1;
                    end
                end
            endcase
        end

        if (rd_en && !sel_ctrl) begin
            if (q.acc == ACC_LOHI && !q.rd_hi) begin
                d.rd_hi = 1'b1;
            end else begin
                d.rd_hi   = 1'b0;
                d.latched = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mode     <= MODE_TC;
            q.acc      <= ACC_LOHI;
            q.wr_hi    <= 1'b0;
            q.lo_stage <= '0;
            q.init     <= '0;
            q.rd_hi    <= 1'b0;
            q.latched  <= 1'b0;
            q.snap     <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_src    = q.latched ? q.snap : count_live;
    assign hi_sel    = (q.acc == ACC_HI) || (q.acc == ACC_LOHI && q.rd_hi);
    assign rd_data   = hi_sel ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];
    assign mode_q    = q.mode;
    assign init_q    = q.init;
    assign snap_held = q.latched;
    assign snap_val  = q.snap;

endmodule

// File: rtl/icc_count_engine.sv
module icc_count_engine
    import icc_pkg::*;
#(
    parameter int CNT_W = 16
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             gate,
    input  icc_mode_e        mode_q,
    input  logic             cfg_load,
    input  icc_mode_e        cfg_mode,
    input  logic             commit,
    input  logic [CNT_W-1:0] init_q,
    output logic [CNT_W-1:0] count_q,
    output logic             out_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] span;
        logic             out;
        logic             armed;
        logic             pend;
        logic             gate_q;
    } eng_st_t;

    eng_st_t q, d;
    logic periodic, rise, wrap;
    logic [CNT_W-1:0] reload, nxt;

    // Zero stands for 2**CNT_W
    function automatic logic [CNT_W:0] widen(input logic [CNT_W-1:0] v);
        return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
    endfunction

    function automatic logic level(input icc_mode_e m, input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] s);
        if (m == MODE_RATE) return (c != ONE);
        else                return widen(c) > (widen(s) >> 1);
    endfunction

    always_comb begin
        d        = q;
        d.gate_q = gate;
        periodic = (mode_q != MODE_TC);
        rise     = gate && !q.gate_q;
        reload   = (init_q == ONE) ? TWO : init_q;
        wrap     = (q.count == ONE);
        nxt      = wrap ? reload : q.count - ONE;

        if (cnt_tick) begin
            if (q.pend) begin
                d.pend  = 1'b0;
                d.armed = 1'b1;
                d.count = periodic ? reload : init_q;
                d.span  = reload;
                d.out   = periodic ? level(mode_q, reload, reload) : 1'b0;
            end else if (q.armed && gate && !(periodic && rise)) begin
                if (periodic) begin
                    d.count = nxt;
                    if (wrap) d.span = reload;
                    d.out   = level(mode_q, nxt, wrap ? reload : q.span);
                end else begin
                    d.count = q.count - ONE;
                    if (wrap) d.out = 1'b1;
                end
            end
        end

        if (periodic && rise && (q.armed || q.pend)) d.pend = 1'b1;

        if (commit) begin
            if (!periodic) begin
                d.pend  = 1'b1;
                d.armed = 1'b0;
                d.out   = 1'b0;
            end else if (!q.armed) begin
                d.pend = 1'b1;
            end
        end

        if (periodic && !gate) d.out = 1'b1;

        if (cfg_load) begin
            d.pend  = 1'b0;
            d.armed = 1'b0;
            d.out   = (cfg_mode == MODE_TC) ? 1'b0 : 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.count  <= '0;
            q.span   <= '0;
            q.out    <= 1'b1;
            q.armed  <= 1'b0;
            q.pend   <= 1'b0;
            q.gate_q <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign count_q = q.count;
    assign out_q   = q.out;

endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
    import icc_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter logic [1:0] CHANNEL_ID = 2'd0
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              sel_ctrl,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cnt_tick,
    input  logic              gate,
    output logic              out
);
    localparam int CNT_W = 2 * DATA_W;

    icc_mode_e        mode_cur;
    icc_mode_e        cfg_mode;
    logic             cfg_load;
    logic             commit;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] count_val;
    logic             snap_held;
    logic [CNT_W-1:0] snap_val;

    icc_host_port #(
        .DATA_W  (DATA_W),
        .CHAN_ID (CHANNEL_ID)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .sel_ctrl   (sel_ctrl),
        .wr_data    (wr_data),
        .count_live (count_val),
        .mode_q     (mode_cur),
        .cfg_load   (cfg_load),
        .cfg_mode   (cfg_mode),
        .commit     (commit),
        .init_q     (init_val),
        .snap_held  (snap_held),
        .snap_val   (snap_val),
        .rd_data    (rd_data)
    );

    icc_count_engine #(
        .CNT_W (CNT_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_tick (cnt_tick),
        .gate     (gate),
        .mode_q   (mode_cur),
        .cfg_load (cfg_load),
        .cfg_mode (cfg_mode),
        .commit   (commit),
        .init_q   (init_val),
        .count_q  (count_val),
        .out_q    (out)
    );

endmodule

// File: rtl/icc_checker.sv
module icc_checker
    import icc_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0,
    parameter int         CNT_W   = 16
)
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             sel_ctrl,
    input logic [7:0]       wr_data,
    input logic             cnt_tick,
    input logic             gate,
    input logic             out,
    input logic [1:0]       mode,
    input logic             latched,
    input logic [CNT_W-1:0] snap
);
    // R2
    foreign_word_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && wr_data[7:6] != CHAN_ID) |=> $stable(mode));

    // R6
    tc_out_holds_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TC && out && !wr_en) |=> out);

    // R8
    rate_low_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RATE && !out && cnt_tick && !wr_en) |=> out);

    // R10
    gate_low_forces_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_TC && !gate && !wr_en) |=> out);

    // R12
    snapshot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !wr_en && !rd_en) |=> (latched && $stable(snap)));

endmodule

bind interval_counter_channel icc_checker #(
    .CHAN_ID (CHANNEL_ID),
    .CNT_W   (CNT_W)
) u_icc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .sel_ctrl (sel_ctrl),
    .wr_data  (wr_data),
    .cnt_tick (cnt_tick),
    .gate     (gate),
    .out      (out),
    .mode     (mode_cur),
    .latched  (snap_held),
    .snap     (snap_val)
);

// File: tb/interval_counter_channel_bench.sv
module interval_counter_channel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       sel_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cnt_tick = 1'b0;
    logic       gate = 1'b1;
    logic       out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    interval_counter_channel u_interval_counter_channel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .sel_ctrl (sel_ctrl),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .cnt_tick (cnt_tick),
        .gate     (gate),
        .out      (out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_tick();
        cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic wr(input logic ctrl, input logic [7:0] b);
        wr_en = 1'b1; sel_ctrl = ctrl; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0; sel_ctrl = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        b = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] lo, hi;
        logic [7:0] ctrl;
        int neff, c;
        logic exp;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R3 reset state
        chk("R3 out", out, 1);
        chk("R3 rd_data", rd_data, 8'h00);

        // R4 low-then-high: low byte alone starts nothing
        wr(1, 8'h30);
        chk("R6 ctrl drives low", out, 0);
        wr(0, 8'h03);
        ticks(10);
        chk("R4 low byte only", out, 0);
        wr(0, 8'h00);
        ticks(3);
        chk("R4 before terminal", out, 0);
        do_tick();
        chk("R4 terminal", out, 1);

        // R4 low-only access, R13 live low-byte read
        wr(1, 8'h10);
        wr(0, 8'h05);
        ticks(5);
        chk("R4 lo-only tick5", out, 0);
        do_tick();
        chk("R4 lo-only tick6", out, 1);
        rd(lo);
        chk("R13 lo-only read", lo, 8'h00);
        ticks(2);
        rd(lo);
        chk("R13 lo-only wrap read", lo, 8'hFE);

        // R4 high-only access (256)
        wr(1, 8'h20);
        wr(0, 8'h01);
        ticks(256);
        chk("R4 hi-only tick256", out, 0);
        do_tick();
        chk("R4 hi-only tick257", out, 1);
        rd(hi);
        chk("R13 hi-only read", hi, 8'h00);
        do_tick();
        rd(hi);
        chk("R13 hi-only wrap read", hi, 8'hFF);

        // R7 gate pauses terminal count
        wr(1, 8'h30);
        wr(0, 8'h06); wr(0, 8'h00);
        ticks(2);
        gate = 1'b0;
        ticks(10);
        chk("R7 paused out", out, 0);
        gate = 1'b1;
        ticks(4);
        chk("R7 resumed before zero", out, 0);
        do_tick();
        chk("R7 resumed zero", out, 1);

        // R10 gate in square-wave mode
        wr(1, 8'h36);
        wr(0, 8'h08); wr(0, 8'h00);
        ticks(6);
        chk("R9 low half", out, 0);
        gate = 1'b0;
        idle();
        chk("R10 forced high", out, 1);
        ticks(3);
        chk("R10 forced high during ticks", out, 1);
        rd(lo); rd(hi);
        chk("R10 count held", {hi, lo}, 16'h0003);
        gate = 1'b1;
        idle();
        do_tick();
        rd(lo); rd(hi);
        chk("R10 reload on rise", {hi, lo}, 16'h0008);
        chk("R10 restart high", out, 1);
        ticks(4);
        chk("R10 restart low half", out, 0);

        // R5 load latency, R12 snapshot, R13 live two-byte read
        wr(1, 8'h30);
        wr(0, 8'h34); wr(0, 8'h12);
        do_tick();
        rd(lo); rd(hi);
        chk("R5 loaded not decremented", {hi, lo}, 16'h1234);
        ticks(4);
        wr(1, 8'h00);
        ticks(3);
        wr(1, 8'h00);
        ticks(2);
        rd(lo); rd(hi);
        chk("R12 snapshot", {hi, lo}, 16'h1230);
        rd(lo); rd(hi);
        chk("R13 live after release", {hi, lo}, 16'h122B);

        // R2 ignored control words
        wr(1, 8'h30);
        wr(0, 8'h02); wr(0, 8'h00);
        ticks(3);
        chk("R6 terminal before R2", out, 1);
        wr(1, 8'h70);
        chk("R2 other channel", out, 1);
        wr(1, 8'h31);
        chk("R2 bcd bit", out, 1);
        wr(1, 8'h32);
        chk("R2 mode 001", out, 1);
        wr(1, 8'hF0);
        chk("R2 channel 3", out, 1);
        wr(0, 8'h02);
        chk("R2 access kept", out, 1);
        wr(0, 8'h00);
        chk("R6 count write drives low", out, 0);
        ticks(3);
        chk("R2 mode kept", out, 1);

        // R14 rate mode: new count waits for reload
        wr(1, 8'h34);
        wr(0, 8'h05); wr(0, 8'h00);
        ticks(2);
        wr(0, 8'h03); wr(0, 8'h00);
        ticks(3);
        chk("R14 old period low", out, 0);
        do_tick();
        chk("R14 reload high", out, 1);
        rd(lo); rd(hi);
        chk("R14 new count at reload", {hi, lo}, 16'h0003);

        // Sweeps: R6 terminal count, R8 rate, R9 square; odd N use aliases (R1)
        for (int md = 0; md < 3; md++) begin
            for (int n = 1; n <= 20; n++) begin
                neff = (md != 0 && n == 1) ? 2 : n;
                if (md == 0)      ctrl = 8'h30;
                else if (md == 1) ctrl = (n % 2 != 0) ? 8'h3C : 8'h34;
                else              ctrl = (n % 2 != 0) ? 8'h3E : 8'h36;
                if (md == 0)           tag = "R6";
                else if (n % 2 != 0)   tag = (md == 1) ? "R8 R1" : "R9 R1";
                else                   tag = (md == 1) ? "R8" : "R9";
                wr(1, ctrl);
                chk(tag, out, (md == 0) ? 0 : 1);
                wr(0, 8'(n)); wr(0, 8'h00);
                for (int k = 1; k <= ((md == 0) ? n + 3 : 3 * neff + 2); k++) begin
                    do_tick();
                    c = neff - ((k - 1) % neff);
                    if (md == 0)      exp = (k >= n + 1);
                    else if (md == 1) exp = (c != 1);
                    else              exp = (c > neff / 2);
                    chk(tag, out, exp);
                end
            end
        end

        // R11 zero means 65536
        wr(1, 8'h30);
        wr(0, 8'h00); wr(0, 8'h00);
        ticks(65536);
        chk("R11 tick65536", out, 0);
        do_tick();
        chk("R11 tick65537", out, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule